// File: doc/BRIEF.md
# ATA Shadow Taskfile Register Set

This block models, on the device side, the shadow registers that one ATA channel exposes to a host: the command-block registers (feature/error, sector count, three address bytes, device, command/status) and the control-block register (device control on writes, alternate status on reads). The host reaches them over a byte-wide register bus with an address, a write strobe, a read strobe, write data and registered read data.

The feature, sector-count and three address registers are each two bytes deep, for 48-bit addressing. Every write pushes the held byte into an older slot. A select bit in the device-control register makes reads return that older byte. Writing the command register emits a one-cycle start pulse with the opcode to the device logic. That logic reports progress back through busy, data-request and error inputs, and signals completion with a pulse. The pulse raises a pending interrupt, which leaves the block on the interrupt request output unless the interrupt-disable bit masks it. A status read clears the pending interrupt. An alternate-status read does not.

Top module: `taskfile_regs`

## Requirements
- R1: After reset every stored register, the start pulse, the read data and the interrupt output are zero.
- R2: Register addresses are: 1 feature (write) / error (read), 2 sector count, 3 address low, 4 address mid, 5 address high, 6 device, 7 command (write) / status (read), 14 device control (write) / alternate status (read). Read data is registered and is valid the cycle after the read strobe. Writes to any other address change nothing, and reads of any other address return zero.
- R3: Each write to a two-deep register (addresses 1 to 5) moves the held byte into the older slot and stores the new byte as the held byte.
- R4: While device-control bit 7 (high-order select) is set, reads of addresses 2 to 5 return the older byte. The device register and status are not affected by this bit.
- R5: Any write to addresses 1 to 7 clears the high-order select bit.
- R6: Reads of address 1 return the `errCode` input. Writes to address 1 load the feature register, which is presented as `featureWord` with the older byte in bits 15:8.
- R7: The device register is a single byte that reads back the value last written.
- R8: A write to address 7 produces `cmdStart` high for exactly the next cycle, with `cmdCode` equal to the written byte.
- R9: The status byte has busy at bit 7, data request at bit 3, error at bit 0 and zero elsewhere. It is sampled from the inputs in the cycle of the read strobe.
- R10: A `cmdDone` pulse makes the interrupt pending. `irq` is high while the interrupt is pending and not masked.
- R11: Device-control bit 1 set masks `irq`. Clearing it while an interrupt is still pending drives `irq` high again.
- R12: A status read clears the pending interrupt. If `cmdDone` arrives in the same cycle, the interrupt stays pending.
- R13: An alternate-status read returns the same byte as a status read and leaves the pending interrupt unchanged.
- R14: The device-control register is write-only: a read of address 14 returns status and never the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| busyIn | input | 1 | Busy indication from device logic |
| drqIn | input | 1 | Data-request indication from device logic |
| errIn | input | 1 | Error indication from device logic |
| errCode | input | 8 | Error register value |
| cmdDone | input | 1 | Command-complete pulse |
| cmdStart | output | 1 | One-cycle pulse after a command write |
| cmdCode | output | 8 | Opcode of the last command write |
| featureWord | output | 16 | Feature register, older byte high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is reading an older byte. The bench must first write each two-deep register twice, then set the high-order select bit with no command-block write in between, because any such write clears the bit again. The directed stimulus fills all four readable two-deep registers and the device register first, sets the select bit last, and reads everything back. It then makes a third write to show that the select bit has cleared and that the shift has moved on. The interrupt sequences also pair a completion pulse with a status read in the same cycle, so the set-over-clear priority is exercised.

// File: rtl/taskfile_pkg.sv
package taskfile_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_DEEP = 5;

  localparam int CTL_NIEN_BIT = 1;
  localparam int CTL_HOB_BIT  = 7;
  localparam int ST_BSY_BIT   = 7;
  localparam int ST_DRQ_BIT   = 3;
  localparam int ST_ERR_BIT   = 0;

  typedef struct packed {
    logic [NUM_DEEP-1:0] deepWr;
    logic                devWr;
    logic                cmdWr;
    logic                rdFire;
    logic [ADDR_W-1:0]   rdAddr;
    logic                hobSel;
  } tfStrobe_t;
endpackage

// File: rtl/taskfile_ctrl.sv
module taskfile_ctrl
  import taskfile_pkg::*;
#(
  parameter int FEAT_ADDR = 1,
  parameter int DEV_ADDR  = 6,
  parameter int CMD_ADDR  = 7,
  parameter int CTL_ADDR  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              ctlHobIn,
  input  logic              ctlMaskIn,
  input  logic              cmdDone,
  output tfStrobe_t         strb,
  output logic              irqMask,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] FeatA = ADDR_W'(FEAT_ADDR);
  localparam logic [ADDR_W-1:0] DevA  = ADDR_W'(DEV_ADDR);
  localparam logic [ADDR_W-1:0] CmdA  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] CtlA  = ADDR_W'(CTL_ADDR);

  logic hobQ, maskQ, pendQ;
  logic ctlWr, blkWr, statusRd;
  logic [NUM_DEEP-1:0] deepHit;

  for (genvar i = 0; i < NUM_DEEP; i++) begin : g_deepDec
    assign deepHit[i] = wrEn && (addr == ADDR_W'(FEAT_ADDR + i));
  end

  assign ctlWr    = wrEn && (addr == CtlA);
  assign blkWr    = wrEn && (addr >= FeatA) && (addr <= CmdA);
  assign statusRd = rdEn && (addr == CmdA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hobQ  <= 1'b0;
      maskQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (ctlWr) begin
        hobQ  <= ctlHobIn;
        maskQ <= ctlMaskIn;
      end else if (blkWr) begin
        hobQ  <= 1'b0;
      end
      if (cmdDone)       pendQ <= 1'b1;
      else if (statusRd) pendQ <= 1'b0;
    end
  end

  always_comb begin
    strb.deepWr = deepHit;
    strb.devWr  = wrEn && (addr == DevA);
    strb.cmdWr  = wrEn && (addr == CmdA);
    strb.rdFire = rdEn;
    strb.rdAddr = addr;
    strb.hobSel = hobQ;
  end

  assign irqMask = maskQ;
  assign irq     = pendQ && !maskQ;
endmodule

// File: rtl/taskfile_datapath.sv
module taskfile_datapath
  import taskfile_pkg::*;
#(
  parameter int FEAT_ADDR = 1,
  parameter int DEV_ADDR  = 6,
  parameter int CMD_ADDR  = 7,
  parameter int CTL_ADDR  = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  tfStrobe_t           strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                busyIn,
  input  logic                drqIn,
  input  logic                errIn,
  input  logic [DATA_W-1:0]   errCode,
  output logic [DATA_W-1:0]   rdData,
  output logic                cmdStart,
  output logic [DATA_W-1:0]   cmdCode,
  output logic [2*DATA_W-1:0] featureWord
);
  logic [DATA_W-1:0] curQ  [NUM_DEEP];
  logic [DATA_W-1:0] prevQ [NUM_DEEP];
  logic [DATA_W-1:0] devQ;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] rdNext;

  for (genvar i = 0; i < NUM_DEEP; i++) begin : g_deep
    always_ff @(posedge clk) begin
      if (!rstN) begin
        curQ[i]  <= '0;
        prevQ[i] <= '0;
      end else if (strb.deepWr[i]) begin
        prevQ[i] <= curQ[i];
        curQ[i]  <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) devQ <= '0;
    else if (strb.devWr) devQ <= wrData;
  end

  always_comb begin
    statusByte = '0;
    statusByte[ST_BSY_BIT] = busyIn;
    statusByte[ST_DRQ_BIT] = drqIn;
    statusByte[ST_ERR_BIT] = errIn;
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdAddr == ADDR_W'(FEAT_ADDR)) rdNext = errCode;
    for (int i = 1; i < NUM_DEEP; i++) begin
      if (strb.rdAddr == ADDR_W'(FEAT_ADDR + i))
        rdNext = strb.hobSel ? prevQ[i] : curQ[i];
    end
    if (strb.rdAddr == ADDR_W'(DEV_ADDR)) rdNext = devQ;
    if ((strb.rdAddr == ADDR_W'(CMD_ADDR)) || (strb.rdAddr == ADDR_W'(CTL_ADDR)))
      rdNext = statusByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      cmdStart <= 1'b0;
      cmdCode  <= '0;
    end else begin
      if (strb.rdFire) rdData <= rdNext;
      cmdStart <= strb.cmdWr;
      if (strb.cmdWr) cmdCode <= wrData;
    end
  end

  assign featureWord = {prevQ[0], curQ[0]};
endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
  import taskfile_pkg::*;
#(
  parameter int FEAT_ADDR = 1,
  parameter int DEV_ADDR  = 6,
  parameter int CMD_ADDR  = 7,
  parameter int CTL_ADDR  = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   busyIn,
  input  logic                   drqIn,
  input  logic                   errIn,
  input  logic [DATA_W-1:0]      errCode,
  input  logic                   cmdDone,
  output logic                   cmdStart,
  output logic [DATA_W-1:0]      cmdCode,
  output logic [2*DATA_W-1:0]    featureWord,
  output logic                   irq
);
  tfStrobe_t strb;
  logic      irqMask;

  taskfile_ctrl #(
    .FEAT_ADDR(FEAT_ADDR), .DEV_ADDR(DEV_ADDR),
    .CMD_ADDR(CMD_ADDR), .CTL_ADDR(CTL_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .ctlHobIn(wrData[CTL_HOB_BIT]), .ctlMaskIn(wrData[CTL_NIEN_BIT]),
    .cmdDone(cmdDone), .strb(strb), .irqMask(irqMask), .irq(irq)
  );

  taskfile_datapath #(
    .FEAT_ADDR(FEAT_ADDR), .DEV_ADDR(DEV_ADDR),
    .CMD_ADDR(CMD_ADDR), .CTL_ADDR(CTL_ADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .busyIn(busyIn), .drqIn(drqIn), .errIn(errIn), .errCode(errCode),
    .rdData(rdData), .cmdStart(cmdStart), .cmdCode(cmdCode),
    .featureWord(featureWord)
  );
endmodule

// File: rtl/taskfile_chk.sv
module taskfile_chk
  import taskfile_pkg::*;
#(
  parameter int FEAT_ADDR = 1,
  parameter int CMD_ADDR  = 7,
  parameter int CTL_ADDR  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              busyIn,
  input logic              drqIn,
  input logic              errIn,
  input logic              cmdDone,
  input logic              cmdStart,
  input logic [DATA_W-1:0] cmdCode,
  input logic              irq,
  input logic              irqMask,
  input logic              hobSel
);
  localparam logic [ADDR_W-1:0] FeatA = ADDR_W'(FEAT_ADDR);
  localparam logic [ADDR_W-1:0] CmdA  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] CtlA  = ADDR_W'(CTL_ADDR);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CtlA && wrData[CTL_NIEN_BIT]) |=> !irq);

  assert_status_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == CmdA && !cmdDone && !wrEn) |=> !irq);

  assert_alt_keeps_R13: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == CtlA && !wrEn && irq) |=> irq);

  assert_done_raises_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !irqMask && !(wrEn && addr == CtlA)) |=> irq);

  assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CmdA) |=> (cmdStart && cmdCode == $past(wrData)));

  assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == CmdA) |=> (rdData[ST_BSY_BIT] == $past(busyIn) &&
      rdData[ST_DRQ_BIT] == $past(drqIn) && rdData[ST_ERR_BIT] == $past(errIn)));

  assert_hob_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= FeatA && addr <= CmdA) |=> !hobSel);
endmodule

bind taskfile_regs taskfile_chk #(
  .FEAT_ADDR(FEAT_ADDR), .CMD_ADDR(CMD_ADDR), .CTL_ADDR(CTL_ADDR)
) i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .busyIn(busyIn), .drqIn(drqIn),
  .errIn(errIn), .cmdDone(cmdDone), .cmdStart(cmdStart), .cmdCode(cmdCode),
  .irq(irq), .irqMask(irqMask), .hobSel(strb.hobSel)
);

// File: tb/test_taskfile_regs.sv
module test_taskfile_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  addr;
  logic        wrEn, rdEn;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic        busyIn, drqIn, errIn;
  logic [7:0]  errCode;
  logic        cmdDone;
  logic        cmdStart;
  logic [7:0]  cmdCode;
  logic [15:0] featureWord;
  logic        irq;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  taskfile_regs i_taskfile_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .busyIn(busyIn), .drqIn(drqIn),
    .errIn(errIn), .errCode(errCode), .cmdDone(cmdDone),
    .cmdStart(cmdStart), .cmdCode(cmdCode), .featureWord(featureWord),
    .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 cmdStart", {15'd0, cmdStart}, 16'd0);
    check("R1 rdData", {8'd0, rdData}, 16'd0);
    check("R1 featureWord", featureWord, 16'd0);
    busRead(4'd2, v);
    check("R1 sector count", {8'd0, v}, 16'd0);
  endtask

  task automatic t_deep();
    logic [7:0] v;
    busWrite(4'd2, 8'h12); busWrite(4'd2, 8'h34);
    busWrite(4'd3, 8'hA1); busWrite(4'd3, 8'hB2);
    busWrite(4'd4, 8'hC3); busWrite(4'd4, 8'hD4);
    busWrite(4'd5, 8'hE5); busWrite(4'd5, 8'hF6);
    busWrite(4'd6, 8'h40);
    busRead(4'd2, v); check("R3 nsect current", {8'd0, v}, 16'h34);
    busRead(4'd5, v); check("R3 lbaHigh current", {8'd0, v}, 16'hF6);
    busRead(4'd6, v); check("R7 device", {8'd0, v}, 16'h40);
    busWrite(4'd14, 8'h80);
    busRead(4'd2, v); check("R4 nsect older", {8'd0, v}, 16'h12);
    busRead(4'd3, v); check("R4 lbaLow older", {8'd0, v}, 16'hA1);
    busRead(4'd4, v); check("R4 lbaMid older", {8'd0, v}, 16'hC3);
    busRead(4'd5, v); check("R4 lbaHigh older", {8'd0, v}, 16'hE5);
    busRead(4'd6, v); check("R4 device unaffected", {8'd0, v}, 16'h40);
    busWrite(4'd2, 8'h56);
    busRead(4'd2, v); check("R5 select cleared", {8'd0, v}, 16'h56);
    busRead(4'd3, v); check("R5 lbaLow current", {8'd0, v}, 16'hB2);
    busWrite(4'd14, 8'h80);
    busRead(4'd2, v); check("R3 shifted older", {8'd0, v}, 16'h34);
    busWrite(4'd6, 8'hE0);
    busRead(4'd2, v); check("R5 device write clears", {8'd0, v}, 16'h56);
    busRead(4'd6, v); check("R7 device rewrite", {8'd0, v}, 16'hE0);
  endtask

  task automatic t_feature();
    logic [7:0] v;
    busWrite(4'd1, 8'h11); busWrite(4'd1, 8'h22);
    check("R6 featureWord", featureWord, 16'h1122);
    errCode = 8'h5A;
    busRead(4'd1, v); check("R6 error read", {8'd0, v}, 16'h5A);
  endtask

  task automatic t_command();
    @(negedge clk);
    addr = 4'd7; wrData = 8'hC8; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8 start pulse", {15'd0, cmdStart}, 16'd1);
    check("R8 opcode", {8'd0, cmdCode}, 16'hC8);
    @(negedge clk);
    check("R8 pulse ends", {15'd0, cmdStart}, 16'd0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    busyIn = 1'b1; drqIn = 1'b0; errIn = 1'b1;
    busRead(4'd7, v); check("R9 status busy+err", {8'd0, v}, 16'h81);
    busyIn = 1'b0; drqIn = 1'b1; errIn = 1'b0;
    busRead(4'd7, v); check("R9 status drq", {8'd0, v}, 16'h08);
    busRead(4'd14, v); check("R13 alt status same", {8'd0, v}, 16'h08);
    busWrite(4'd14, 8'h82);
    busRead(4'd14, v); check("R14 control not readable", {8'd0, v}, 16'h08);
    busWrite(4'd14, 8'h00);
    drqIn = 1'b0;
  endtask

  task automatic t_irq();
    logic [7:0] v;
    busWrite(4'd14, 8'h00);
    pulseDone();
    check("R10 irq raised", {15'd0, irq}, 16'd1);
    busRead(4'd14, v);
    check("R13 alt read keeps irq", {15'd0, irq}, 16'd1);
    busRead(4'd7, v);
    check("R12 status read clears", {15'd0, irq}, 16'd0);
    pulseDone();
    busWrite(4'd14, 8'h02);
    check("R11 masked", {15'd0, irq}, 16'd0);
    busWrite(4'd14, 8'h00);
    check("R11 unmasked pending", {15'd0, irq}, 16'd1);
    busRead(4'd7, v);
    check("R12 cleared again", {15'd0, irq}, 16'd0);
    busWrite(4'd14, 8'h02);
    pulseDone();
    check("R10 pending but masked", {15'd0, irq}, 16'd0);
    busWrite(4'd14, 8'h00);
    check("R10 pending shows", {15'd0, irq}, 16'd1);
    busRead(4'd7, v);
    @(negedge clk);
    addr = 4'd7; rdEn = 1'b1; cmdDone = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; cmdDone = 1'b0;
    check("R12 done wins over read", {15'd0, irq}, 16'd1);
    busRead(4'd7, v);
    check("R12 final clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    busWrite(4'd9, 8'hFF);
    busRead(4'd9, v); check("R2 unmapped read zero", {8'd0, v}, 16'd0);
    busRead(4'd2, v); check("R2 unmapped write ignored", {8'd0, v}, 16'h56);
    check("R2 feature untouched", featureWord, 16'h1122);
    check("R2 irq untouched", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    busyIn = 1'b0; drqIn = 1'b0; errIn = 1'b0; errCode = '0; cmdDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_deep();
    t_feature();
    t_command();
    t_status();
    t_irq();
    t_unmapped();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule